// File: doc/BRIEF.md
# Receive descriptor ring writer

This block stores one incoming frame at a time into a circular ring of receive descriptors kept in system memory. It uses a simple single-request memory master: one read or write at a time, each held until the memory acknowledges it. A start pulse brings the frame length and the layout style. The block then takes the frame bytes from a valid/ready byte stream, finds the current descriptor, checks that software owns it, and copies the bytes into that descriptor's buffer. When one buffer is not large enough, the frame continues into the following descriptors. At the end the block writes the status words back.

Each descriptor is four 32-bit words. Two word layouts are supported, and they differ only in where the buffer address and the message count sit. Buffer sizes are held in negated form. The ring position is internal. It persists from frame to frame and is visible only through the addresses the block uses. A frame that finds no owned descriptor at its start is refused, and its bytes are consumed and discarded. A frame that runs out of owned descriptors part-way is closed with an error mark.

Top module: `rxr_ring_writer`

## Requirements
- R1: The current descriptor starts at `ring_base + 16*pos`, where pos is the ring position (0 after reset). The flag word sits at offset +4 and is always read first, at that address.
- R2: With `layout_sel` = 2, the buffer address word is at +0 and the count word is at +8. With `layout_sel` = 3, these two words are swapped: the buffer address is at +8 and the count is at +0. Any other value drops the frame without any memory access.
- R3: The ring position advances by one for every descriptor used, and it wraps to 0 after position `2**ring_l2len - 1`. The ring length is limited to `2**RING_L2_MAX` descriptors.
- R4: If bit 31 (owned) of the first flag word is 0, the block pulses `done` together with `dropped`. In that case it performs no write, leaves the ring position unchanged and consumes all `frame_len` bytes.
- R5: The buffer size is the two's complement of flag bits [11:0], taken modulo 4096. Each buffer receives the smaller of its size and the number of bytes still to be stored.
- R6: Bytes are packed little-endian: byte k of a buffer goes to lane k mod 4 of the word at `buffer + 4*(k/4)`. A final partial word carries byte enables only for its filled lanes.
- R7: A frame longer than `MAX_FRAME` is cut to `MAX_FRAME` stored bytes. The excess bytes are still consumed from the stream and are discarded.
- R8: After the last stored byte, the last descriptor's flag word gets bit 24 (end) set. The count word is written with the stored length plus 4 in bits [11:0] and zeros in bits [31:12].
- R9: Every descriptor after the first has its flag word written back at +4 with bit 31 cleared once its buffer is full or the frame ends. All other flag bits are kept.
- R10: Before moving on to a next descriptor, the block reads that descriptor's flag word. If bit 31 of that word is 0, the current flag word gets bits 30 (error), 26 (buffer fault) and 24 (end) set. The frame then ends without a count write.
- R11: The first descriptor's flag word is written last, with bit 31 cleared. `done` and `rx_irq` are then pulsed together for one cycle.
- R12: A memory request keeps its address, direction and write data stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_l2len | input | 4 | Log2 of the number of descriptors |
| layout_sel | input | 8 | Descriptor word layout, 2 or 3 |
| start | input | 1 | Begin a frame, one-cycle pulse |
| frame_len | input | LEN_W | Frame byte count, sampled with start |
| in_valid | input | 1 | Frame byte available |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Frame finished, one-cycle pulse |
| dropped | output | 1 | With done: frame refused |
| rx_irq | output | 1 | With done: frame stored |

## Verification
The bench tries single-buffer frames whose lengths end on and off word boundaries, which separates full-word writes from partial byte enables. It also runs a three-buffer chain and a chain that fills both buffers exactly, which show whether chaining, the size decode and the ordering of the write-back are right. It uses frames in each of the two layouts, which tell the swapped address and count words apart. Further frames with an unowned first or next descriptor, a bad layout value and an over-long frame separate refusal, error closing and truncation. A final frame after ring wraparound confirms the ring position through the addresses it uses.

// File: rtl/rxr_pkg.sv
// Shared constants and state encoding for the receive ring writer.
package rxr_pkg;
    localparam int DESC_SHIFT = 4;   // 16 bytes per descriptor
    localparam int OWN_B      = 31;
    localparam int ERR_B      = 30;
    localparam int BUFF_B     = 26;
    localparam int ENP_B      = 24;
    localparam int CW         = 12;  // width of size and count fields

    typedef enum logic [3:0] {
        S_IDLE, S_RD_FLAG, S_RD_ADDR, S_GET, S_WR_DATA, S_END_DESC,
        S_RD_NEXT, S_WR_FLAG, S_WR_COUNT, S_WR_FIRST, S_DRAIN, S_FINISH
    } rxr_state_e;
endpackage

// File: rtl/rxr_ring_pos.sv
// Ring position counter and current descriptor address.
// Assumes ring_base and ring_l2len stay constant while frames are handled.
module rxr_ring_pos import rxr_pkg::*; #(
    parameter int AW     = 32,
    parameter int L2_MAX = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic [3:0]    ring_l2len,
    input  logic          advance,
    output logic [AW-1:0] cur_addr
);
    localparam int POS_W = (L2_MAX < 1) ? 1 : L2_MAX;

    logic [3:0]       l2_eff;
    logic [POS_W:0]   ring_size;
    logic [POS_W-1:0] pos;
    logic             at_last;

    assign l2_eff    = (ring_l2len > 4'(L2_MAX)) ? 4'(L2_MAX) : ring_l2len;
    assign ring_size = {{POS_W{1'b0}}, 1'b1} << l2_eff;
    assign at_last   = ({1'b0, pos} == ring_size - 1'b1);
    assign cur_addr  = ring_base + (AW'(pos) << DESC_SHIFT);

    // Step the position, wrapping after the last descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos <= '0;
        else if (advance) pos <= at_last ? '0 : pos + 1'b1;
    end

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pos} < ring_size));
endmodule

// File: rtl/rxr_byte_pack.sv
// Packs bytes into a little-endian 32-bit word, tracking filled lanes.
// Assumes clear and load are never high in the same cycle.
module rxr_byte_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    input  logic        clear,
    output logic [31:0] word,
    output logic [3:0]  be
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       en_q;
        // Hold one byte lane and its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
                en_q   <= 1'b0;
            end else if (clear) begin
                en_q <= 1'b0;
            end else if (load && lane == 2'(g)) begin
                byte_q <= din;
                en_q   <= 1'b1;
            end
        end
        assign word[g*8 +: 8] = byte_q;
        assign be[g]          = en_q;
    end

    // R6
    lane_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !be[lane]);
endmodule

// File: rtl/rxr_ring_writer.sv
// Receive descriptor ring writer: stores one frame into owned descriptors,
// chaining across buffers, then writes flags and count back.
// Assumes buffer addresses are word aligned and MAX_FRAME + 4 < 4096.
module rxr_ring_writer import rxr_pkg::*; #(
    parameter int AW          = 32,
    parameter int LEN_W       = 16,
    parameter int MAX_FRAME   = 1518,
    parameter int RING_L2_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic [3:0]       ring_l2len,
    input  logic [7:0]       layout_sel,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic             dropped,
    output logic             rx_irq
);
    localparam logic [CW-1:0] TRUNC = CW'(MAX_FRAME);

    rxr_state_e       state;
    logic [LEN_W-1:0] flen, bytes_in;
    logic [CW-1:0]    tlen, rem, chunk_left, off;
    logic [AW-1:0]    cur_addr_r, first_addr, buf_addr, waddr, pos_addr;
    logic [31:0]      flag_r, first_flag, nflag;
    logic             first_q, chain_q, err_q, drop_q, style3, wrote;
    logic [CW-1:0]    size, chunk_nxt, tlen_in;
    logic             pk_load, pk_clear;
    logic [31:0]      pk_word;
    logic [3:0]       pk_be;

    assign size      = ~flag_r[CW-1:0] + 1'b1;
    assign chunk_nxt = (size < rem) ? size : rem;
    assign tlen_in   = (frame_len > LEN_W'(MAX_FRAME)) ? TRUNC : CW'(frame_len);
    assign pk_load   = (state == S_GET) && in_valid;
    assign pk_clear  = (state == S_WR_DATA) && mem_ack;

    rxr_ring_pos #(.AW(AW), .L2_MAX(RING_L2_MAX)) u_pos (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .ring_l2len(ring_l2len), .advance(state == S_END_DESC),
        .cur_addr(pos_addr));

    rxr_byte_pack u_pack (
        .clk(clk), .rst_n(rst_n), .load(pk_load), .lane(off[1:0]),
        .din(in_data), .clear(pk_clear), .word(pk_word), .be(pk_be));

    // Drive the memory request and the stream handshake from the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'hF;
        in_ready  = 1'b0;
        unique case (state)
            S_RD_FLAG: begin mem_req = 1'b1; mem_addr = cur_addr_r + AW'(4); end
            S_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr_r + (style3 ? AW'(8) : AW'(0));
            end
            S_GET:     in_ready = 1'b1;
            S_WR_DATA: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = waddr;
                mem_wdata = pk_word; mem_be = pk_be;
            end
            S_RD_NEXT: begin mem_req = 1'b1; mem_addr = pos_addr + AW'(4); end
            S_WR_FLAG: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_addr_r + AW'(4);
                mem_wdata = flag_r & ~(32'd1 << OWN_B);
            end
            S_WR_COUNT: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = cur_addr_r + (style3 ? AW'(0) : AW'(8));
                mem_wdata = {{(32-CW){1'b0}}, tlen + CW'(4)};
            end
            S_WR_FIRST: begin
                mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_addr + AW'(4);
                mem_wdata = (first_q ? flag_r : first_flag) & ~(32'd1 << OWN_B);
            end
            S_DRAIN:   in_ready = (bytes_in != flen);
            default: ;
        endcase
    end

    assign done    = (state == S_FINISH);
    assign dropped = done && drop_q;
    assign rx_irq  = done && !drop_q;

    // Sequence descriptor reads, buffer fills and write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            flen <= '0; bytes_in <= '0; tlen <= '0; rem <= '0;
            chunk_left <= '0; off <= '0;
            cur_addr_r <= '0; first_addr <= '0; buf_addr <= '0; waddr <= '0;
            flag_r <= '0; first_flag <= '0; nflag <= '0;
            first_q <= 1'b0; chain_q <= 1'b0; err_q <= 1'b0;
            drop_q <= 1'b0; style3 <= 1'b0; wrote <= 1'b0;
        end else begin
            if (mem_req && mem_we && mem_ack) wrote <= 1'b1;
            if ((state == S_GET || state == S_DRAIN) && in_ready && in_valid)
                bytes_in <= bytes_in + 1'b1;
            unique case (state)
                S_IDLE: if (start) begin
                    flen <= frame_len; tlen <= tlen_in; rem <= tlen_in;
                    bytes_in <= '0; wrote <= 1'b0;
                    first_q <= 1'b1; chain_q <= 1'b0; err_q <= 1'b0;
                    cur_addr_r <= pos_addr; first_addr <= pos_addr;
                    style3 <= (layout_sel == 8'd3);
                    if (layout_sel != 8'd2 && layout_sel != 8'd3) begin
                        drop_q <= 1'b1; state <= S_DRAIN;
                    end else begin
                        drop_q <= 1'b0; state <= S_RD_FLAG;
                    end
                end
                S_RD_FLAG: if (mem_ack) begin
                    if (!mem_rdata[OWN_B]) begin
                        drop_q <= 1'b1; state <= S_DRAIN;
                    end else begin
                        flag_r <= mem_rdata; state <= S_RD_ADDR;
                    end
                end
                S_RD_ADDR: if (mem_ack) begin
                    buf_addr   <= mem_rdata;
                    chunk_left <= chunk_nxt;
                    off        <= '0;
                    state      <= (chunk_nxt == '0) ? S_END_DESC : S_GET;
                end
                S_GET: if (in_valid) begin
                    waddr      <= buf_addr + AW'({off[CW-1:2], 2'b00});
                    off        <= off + 1'b1;
                    rem        <= rem - 1'b1;
                    chunk_left <= chunk_left - 1'b1;
                    if (off[1:0] == 2'd3 || chunk_left == CW'(1)) state <= S_WR_DATA;
                end
                S_WR_DATA: if (mem_ack)
                    state <= (chunk_left == '0) ? S_END_DESC : S_GET;
                S_END_DESC: begin
                    if (rem == '0) begin
                        flag_r[ENP_B] <= 1'b1;
                        state <= first_q ? S_WR_COUNT : S_WR_FLAG;
                    end else begin
                        state <= S_RD_NEXT;
                    end
                end
                S_RD_NEXT: if (mem_ack) begin
                    nflag <= mem_rdata;
                    if (mem_rdata[OWN_B]) begin
                        if (first_q) begin
                            first_flag <= flag_r; first_q <= 1'b0;
                            flag_r <= mem_rdata; cur_addr_r <= pos_addr;
                            state <= S_RD_ADDR;
                        end else begin
                            chain_q <= 1'b1; state <= S_WR_FLAG;
                        end
                    end else begin
                        flag_r[ERR_B]  <= 1'b1;
                        flag_r[BUFF_B] <= 1'b1;
                        flag_r[ENP_B]  <= 1'b1;
                        err_q <= 1'b1;
                        state <= first_q ? S_WR_FIRST : S_WR_FLAG;
                    end
                end
                S_WR_FLAG: if (mem_ack) begin
                    if (chain_q) begin
                        chain_q <= 1'b0; flag_r <= nflag;
                        cur_addr_r <= pos_addr; state <= S_RD_ADDR;
                    end else begin
                        state <= err_q ? S_WR_FIRST : S_WR_COUNT;
                    end
                end
                S_WR_COUNT: if (mem_ack) state <= S_WR_FIRST;
                S_WR_FIRST: if (mem_ack) state <= S_DRAIN;
                S_DRAIN:  if (bytes_in == flen) state <= S_FINISH;
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
    // R4
    drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |-> !wrote);
    // R11
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (done && !dropped));
    // R7
    no_overread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |-> (bytes_in < flen));
endmodule

// File: tb/rxr_ring_writer_test.sv
// Scoreboard bench: the driver queues expected writes, the monitor compares.
module rxr_ring_writer_test;
    localparam int BASE = 32'h100;
    localparam int L2   = 2;
    localparam int MAXF = 64;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        string       tag;
    } wr_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] layout_sel = 8'd2;
    logic start = 1'b0, in_valid = 1'b0;
    logic [15:0] frame_len = '0;
    logic [7:0] in_data = '0;
    logic in_ready, mem_req, mem_we, mem_ack = 1'b0, done, dropped, rx_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [3:0] mem_be;

    logic [31:0] mem [0:1023];
    wr_t expq[$];
    int errors = 0, checks = 0, cycles = 0, mpos = 0;
    bit exp_drop = 1'b0, frame_done = 1'b0, pend = 1'b0;
    logic [31:0] pend_addr = '0;
    string ftag = "";

    always #10 clk = ~clk;

    rxr_ring_writer #(.MAX_FRAME(MAXF), .RING_L2_MAX(4)) uut (
        .clk(clk), .rst_n(rst_n), .ring_base(32'(BASE)), .ring_l2len(4'(L2)),
        .layout_sel(layout_sel), .start(start), .frame_len(frame_len),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .dropped(dropped), .rx_irq(rx_irq));

    // Memory model: acknowledges one cycle after a request is seen.
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we)
                for (int j = 0; j < 4; j++)
                    if (mem_be[j]) mem[mem_addr[11:2]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int b, input int s);
        return 8'((b * 13 + s) & 255);
    endfunction

    // Monitor: compares writes in order, checks completion flags and holding.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend)
                chk(mem_req && mem_addr == pend_addr, "R12", "request held",
                    {31'b0, mem_req}, pend_addr);
            pend = mem_req && !mem_ack;
            pend_addr = mem_addr;
            if (mem_req && mem_ack && mem_we) begin
                if (expq.size() == 0) begin
                    chk(1'b0, {"R4/", ftag}, "unexpected write", mem_addr, 32'h0);
                end else begin
                    wr_t w;
                    w = expq.pop_front();
                    chk(mem_addr == w.a, {w.tag, "/", ftag}, "write address", mem_addr, w.a);
                    chk(mem_be == w.be, {w.tag, "/", ftag}, "byte enables", 32'(mem_be), 32'(w.be));
                    for (int j = 0; j < 4; j++)
                        if (w.be[j])
                            chk(mem_wdata[j*8 +: 8] == w.d[j*8 +: 8], {w.tag, "/", ftag},
                                "write data lane", mem_wdata, w.d);
                end
            end
            if (done) begin
                chk(expq.size() == 0, {"R11/", ftag}, "missing writes", 32'(expq.size()), 0);
                chk(dropped == exp_drop, {"R4/", ftag}, "dropped flag", 32'(dropped), 32'(exp_drop));
                chk(rx_irq == !exp_drop, {"R11/", ftag}, "irq flag", 32'(rx_irq), 32'(!exp_drop));
                frame_done = 1'b1;
            end
        end
    end

    // Watchdog: a hung run is one failed check, then the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R11", "watchdog expired", 32'(cycles), 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_desc(input int idx, input int bufa, input int size,
                            input bit own, input int style);
        int a;
        a = BASE + 16 * idx;
        mem[(a + 4) >> 2] = {own, 15'b0, 4'hF, 12'((4096 - size) % 4096)};
        mem[((style == 3) ? a + 8 : a) >> 2] = 32'(bufa);
        mem[((style == 3) ? a : a + 8) >> 2] = 32'hDEAD0000;
    endtask

    task automatic push(input int a, input logic [31:0] d, input string tag);
        wr_t w;
        w.a = 32'(a); w.d = d; w.be = 4'hF; w.tag = tag;
        expq.push_back(w);
    endtask

    // Expected write sequence, derived from the requirements.
    task automatic build_expect(input int flen, input int style, input int seed);
        int cur, faddr, t, rem, bidx, size, chunk, nxt;
        logic [31:0] flag, fflag, nflag, bufa;
        bit first;
        exp_drop = 1'b0;
        if (style != 2 && style != 3) begin exp_drop = 1'b1; return; end
        cur  = BASE + 16 * mpos;
        flag = mem[(cur + 4) >> 2];
        if (!flag[31]) begin exp_drop = 1'b1; return; end
        t = (flen > MAXF) ? MAXF : flen;
        rem = t; first = 1'b1; faddr = cur; fflag = flag; bidx = 0;
        forever begin
            bufa  = mem[((style == 3) ? cur + 8 : cur) >> 2];
            size  = (4096 - int'(flag[11:0])) % 4096;
            chunk = (size < rem) ? size : rem;
            for (int k = 0; k < chunk; k += 4) begin
                wr_t w;
                w.a = bufa + 32'(k); w.d = '0; w.be = '0; w.tag = "R5/R6";
                for (int j = 0; j < 4; j++)
                    if (k + j < chunk) begin
                        w.d[j*8 +: 8] = pat(bidx, seed); w.be[j] = 1'b1; bidx++;
                    end
                expq.push_back(w);
            end
            rem -= chunk;
            mpos = (mpos + 1) % (1 << L2);
            if (rem == 0) begin
                flag[24] = 1'b1;
                if (!first) push(cur + 4, flag & 32'h7FFF_FFFF, "R9");
                push(cur + ((style == 3) ? 0 : 8), 32'(t + 4), (style == 3) ? "R2/R8" : "R8");
                break;
            end
            nxt = BASE + 16 * mpos;
            nflag = mem[(nxt + 4) >> 2];
            if (!nflag[31]) begin
                flag = flag | 32'h4500_0000;
                if (!first) push(cur + 4, flag & 32'h7FFF_FFFF, "R10");
                break;
            end
            if (!first) push(cur + 4, flag & 32'h7FFF_FFFF, "R9");
            else fflag = flag;
            first = 1'b0; cur = nxt; flag = nflag;
        end
        push(faddr + 4, (first ? flag : fflag) & 32'h7FFF_FFFF, "R1/R11");
    endtask

    // Driver: queue expectations, pulse start, stream bytes, await done.
    task automatic run_frame(input int flen, input int style, input int seed,
                             input string tag);
        ftag = tag;
        build_expect(flen, style, seed);
        frame_done = 1'b0;
        @(negedge clk);
        layout_sel = 8'(style); frame_len = 16'(flen); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < flen; b++) begin
            if (b != 0) @(negedge clk);
            in_valid = 1'b1; in_data = pat(b, seed);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (!frame_done) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
        repeat (4) @(negedge clk);
        chk(!mem_req && !done && !in_ready && !rx_irq, "R11", "reset state",
            {mem_req, done, in_ready, rx_irq}, 0);
        rst_n = 1'b1;
        // R1: single buffer, partial last word
        set_desc(0, 32'h400, 64, 1'b1, 2);
        run_frame(10, 2, 3, "R1");
        // R5: three-buffer chain, wraps to position 0 (R3)
        set_desc(1, 32'h500, 20, 1'b1, 2);
        set_desc(2, 32'h600, 20, 1'b1, 2);
        set_desc(3, 32'h700, 64, 1'b1, 2);
        run_frame(50, 2, 7, "R3");
        // R2: swapped layout at position 0
        set_desc(0, 32'h800, 32, 1'b1, 3);
        run_frame(8, 3, 11, "R2");
        // R10: next descriptor not owned
        set_desc(1, 32'h500, 16, 1'b1, 2);
        set_desc(2, 32'h600, 16, 1'b0, 2);
        run_frame(40, 2, 5, "R10");
        // R4: first descriptor not owned, position stays 2
        run_frame(5, 2, 1, "R4");
        // R2: invalid layout value
        run_frame(6, 1, 2, "R2");
        // R7: truncation to MAX_FRAME
        set_desc(2, 32'h900, 128, 1'b1, 2);
        run_frame(70, 2, 9, "R7");
        // R5: exact fill of two buffers, wrapping inside the frame
        set_desc(3, 32'h400, 8, 1'b1, 2);
        set_desc(0, 32'h480, 8, 1'b1, 2);
        run_frame(16, 2, 4, "R5");
        // R3: position must now be 1
        set_desc(1, 32'h600, 40, 1'b1, 2);
        run_frame(4, 2, 6, "R3");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule